// File: doc/BRIEF.md
# Dual Condition Code Compare Unit

This block holds the two condition flags of a vector shading core. The first flag belongs to the x lane and the second to the y lane. When a compare operation is issued, the block receives the x and the y components of two 24-bit floating-point operands. Each lane has its own 3-bit relation selector. Each lane's result is written into its own flag on the next clock edge. The z and w components never reach this block, because a compare leaves them out of the result.

Flow-control operations query the same flags through a combinational path. Two reference bits are each checked against their own flag, and a 2-bit combine mode reduces the two matches to a single taken bit. Operand fetch, swizzle, negation and program sequencing are done by the surrounding core.

Top module: `cc_dual_compare`

## Requirements
- R1: While `rst_n` is low, both flags are 0, and they stay 0 until a compare is accepted.
- R2: On a rising edge with `cmp_en` high, `flag_x` takes the result of comparing `a_x` with `b_x`, and `flag_y` takes the result of comparing `a_y` with `b_y`. On an edge with `cmp_en` low, both flags keep their values.
- R3: The selector encoding is 0 equal, 1 not-equal, 2 a<b, 3 a<=b, 4 a>b, 5 a>=b.
- R4: Operands are ordered in sign-magnitude form. Bit 23 is the sign and bits 22:0 are the magnitude. Any negative value is below any positive value, and among negative values the larger magnitude is the smaller value.
- R5: +0 (0x000000) and -0 (0x800000) compare as equal.
- R6: Selector values 6 and 7 leave that lane's flag unchanged, even when `cmp_en` is high. The other lane still updates.
- R7: Each lane uses its own selector (`sel_x` for the x lane, `sel_y` for the y lane), so the two lanes can apply different relations in the same compare.
- R8: `taken` is combinational. With match_x = (ref_x == flag_x) and match_y = (ref_y == flag_y), mode 0 gives match_x OR match_y, mode 1 gives match_x AND match_y, mode 2 gives match_x, and mode 3 gives match_y.
- R9: When a compare and a branch query fall in the same cycle, `taken` is computed from the flags held before that compare's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Accept a compare on this edge |
| a_x | input | 24 | First operand, x component |
| a_y | input | 24 | First operand, y component |
| b_x | input | 24 | Second operand, x component |
| b_y | input | 24 | Second operand, y component |
| sel_x | input | 3 | Relation selector for the x lane |
| sel_y | input | 3 | Relation selector for the y lane |
| ref_x | input | 1 | Reference bit tested against flag_x |
| ref_y | input | 1 | Reference bit tested against flag_y |
| mode | input | 2 | Combine mode for the branch test |
| flag_x | output | 1 | Condition flag of the x lane |
| flag_y | output | 1 | Condition flag of the y lane |
| taken | output | 1 | Branch condition result |

## Verification
A compare and a branch query can occur in the same cycle. In that cycle `taken` reads the flags while the compare is only preparing the next edge's update. The bench provokes this case by presenting a compare that inverts both flags while it holds the reference bits and mode steady. Before the edge it requires `taken` to match the old flags, and after the edge it requires `taken` to match the new flags. The compare sweep separately runs every operand pair from a set that includes both zeros, with all eight selectors on each lane, and predicts each result from signed integer keys computed in the bench.

// File: rtl/cc_cmp_pkg.sv
package cc_cmp_pkg;

   typedef enum logic [2:0] {
      SEL_EQ   = 3'd0,
      SEL_NE   = 3'd1,
      SEL_LT   = 3'd2,
      SEL_LE   = 3'd3,
      SEL_GT   = 3'd4,
      SEL_GE   = 3'd5,
      SEL_RSV6 = 3'd6,
      SEL_RSV7 = 3'd7
   } cmp_sel_e;

   typedef enum logic [1:0] {
      CMB_OR  = 2'd0,
      CMB_AND = 2'd1,
      CMB_X   = 2'd2,
      CMB_Y   = 2'd3
   } cmb_mode_e;

   typedef struct packed {
      logic lt;
      logic eq;
   } order_t;

   function automatic logic sel_defined(cmp_sel_e s);
      return (s <= SEL_GE);
   endfunction

endpackage

// File: rtl/cc_float_order.sv
module cc_float_order #(
   parameter int W       = 24,
   parameter bit ZERO_EQ = 1'b1
) (
   input  logic [W-1:0]       a,
   input  logic [W-1:0]       b,
   output cc_cmp_pkg::order_t ord
);
   localparam int MAG_W = W - 1;

   if (W < 2) begin : g_bad_width
      $error("cc_float_order: W must be at least 2");
   end

   logic             sgn_a, sgn_b;
   logic [MAG_W-1:0] mag_a, mag_b;
   cc_cmp_pkg::order_t raw;

   assign sgn_a = a[W-1];
   assign sgn_b = b[W-1];
   assign mag_a = a[MAG_W-1:0];
   assign mag_b = b[MAG_W-1:0];

   always_comb begin
      raw = '0;
      if (a == b) begin
         raw.eq = 1'b1;
      end else if (sgn_a != sgn_b) begin
         raw.lt = sgn_a;
      end else if (!sgn_a) begin
         raw.lt = (mag_a < mag_b);
      end else begin
         raw.lt = (mag_a > mag_b);
      end
   end

   if (ZERO_EQ) begin : g_signed_zero_equal
      logic both_zero;
      assign both_zero = (mag_a == '0) && (mag_b == '0);
      always_comb begin
         ord = raw;
         if (both_zero) begin
            ord.lt = 1'b0;
            ord.eq = 1'b1;
         end
      end
   end else begin : g_signed_zero_ordered
      assign ord = raw;
   end

endmodule

// File: rtl/cc_flag_lane.sv
module cc_flag_lane #(
   parameter int W       = 24,
   parameter bit ZERO_EQ = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [2:0]   sel,
   output logic         flag
);
   import cc_cmp_pkg::*;

   order_t   ord;
   cmp_sel_e sel_e;
   logic     hit;
   logic     upd;

   cc_float_order #(.W(W), .ZERO_EQ(ZERO_EQ)) u_order (
      .a   (a),
      .b   (b),
      .ord (ord)
   );

   assign sel_e = cmp_sel_e'(sel);

   always_comb begin
      unique case (sel_e)
         SEL_EQ:  hit = ord.eq;
         SEL_NE:  hit = !ord.eq;
         SEL_LT:  hit = ord.lt;
         SEL_LE:  hit = ord.lt || ord.eq;
         SEL_GT:  hit = !ord.lt && !ord.eq;
         SEL_GE:  hit = !ord.lt;
         default: hit = 1'b0;
      endcase
   end

   assign upd = en && sel_defined(sel_e);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (upd) begin
         flag <= hit;
      end
   end

endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval #(
   parameter int LANES = 2
) (
   input  logic [LANES-1:0] flags,
   input  logic [LANES-1:0] refs,
   input  logic [1:0]       mode,
   output logic             taken
);
   import cc_cmp_pkg::*;

   if (LANES != 2) begin : g_bad_lanes
      $error("cc_branch_eval: combine modes are defined for two lanes");
   end

   logic [LANES-1:0] match;

   for (genvar i = 0; i < LANES; i++) begin : g_match
      assign match[i] = (refs[i] == flags[i]);
   end

   always_comb begin
      unique case (cmb_mode_e'(mode))
         CMB_OR:  taken = |match;
         CMB_AND: taken = &match;
         CMB_X:   taken = match[0];
         CMB_Y:   taken = match[1];
         default: taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/cc_dual_compare.sv
module cc_dual_compare #(
   parameter int FLT_W   = 24,
   parameter bit ZERO_EQ = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_en,
   input  logic [FLT_W-1:0] a_x,
   input  logic [FLT_W-1:0] a_y,
   input  logic [FLT_W-1:0] b_x,
   input  logic [FLT_W-1:0] b_y,
   input  logic [2:0]       sel_x,
   input  logic [2:0]       sel_y,
   input  logic             ref_x,
   input  logic             ref_y,
   input  logic [1:0]       mode,
   output logic             flag_x,
   output logic             flag_y,
   output logic             taken
);
   localparam int LANES = 2;

   logic [FLT_W-1:0] op_a [LANES];
   logic [FLT_W-1:0] op_b [LANES];
   logic [2:0]       sel  [LANES];
   logic [LANES-1:0] flags;

   assign op_a[0] = a_x;
   assign op_a[1] = a_y;
   assign op_b[0] = b_x;
   assign op_b[1] = b_y;
   assign sel[0]  = sel_x;
   assign sel[1]  = sel_y;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      cc_flag_lane #(.W(FLT_W), .ZERO_EQ(ZERO_EQ)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (cmp_en),
         .a     (op_a[i]),
         .b     (op_b[i]),
         .sel   (sel[i]),
         .flag  (flags[i])
      );
   end

   cc_branch_eval #(.LANES(LANES)) u_branch (
      .flags (flags),
      .refs  ({ref_y, ref_x}),
      .mode  (mode),
      .taken (taken)
   );

   assign flag_x = flags[0];
   assign flag_y = flags[1];

endmodule

// File: rtl/cc_dual_compare_chk.sv
module cc_dual_compare_chk #(
   parameter int W = 24
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cmp_en,
   input logic [W-1:0] a_x,
   input logic [W-1:0] b_x,
   input logic [2:0]   sel_x,
   input logic [2:0]   sel_y,
   input logic         ref_x,
   input logic         ref_y,
   input logic [1:0]   mode,
   input logic         flag_x,
   input logic         flag_y,
   input logic         taken
);

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (!flag_x && !flag_y));

   a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en |=> (flag_x == $past(flag_x) && flag_y == $past(flag_y)));

   a_r6_undef_x_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && sel_x >= 3'd6) |=> (flag_x == $past(flag_x)));

   a_r6_undef_y_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && sel_y >= 3'd6) |=> (flag_y == $past(flag_y)));

   a_r3_equal_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && sel_x == 3'd0 && a_x == b_x) |=> flag_x);

   a_r8_and_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1 && taken) |-> (ref_x == flag_x && ref_y == flag_y));

   a_r8_x_only: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2) |-> (taken == (ref_x == flag_x)));

   a_r8_y_only: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3) |-> (taken == (ref_y == flag_y)));

endmodule

bind cc_dual_compare cc_dual_compare_chk #(.W(FLT_W)) u_chk (.*);

// File: tb/cc_dual_compare_tb.sv
`timescale 1ns/1ps
module cc_dual_compare_tb;
   localparam int W = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmp_en = 1'b0;
   logic [W-1:0] a_x = '0, a_y = '0, b_x = '0, b_y = '0;
   logic [2:0]   sel_x = '0, sel_y = '0;
   logic         ref_x = 1'b0, ref_y = 1'b0;
   logic [1:0]   mode = '0;
   logic         flag_x, flag_y, taken;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   bit exp_fx  = 1'b0;
   bit exp_fy  = 1'b0;

   always #2.5 clk = ~clk;

   cc_dual_compare u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en),
      .a_x(a_x), .a_y(a_y), .b_x(b_x), .b_y(b_y),
      .sel_x(sel_x), .sel_y(sel_y), .ref_x(ref_x), .ref_y(ref_y),
      .mode(mode), .flag_x(flag_x), .flag_y(flag_y), .taken(taken)
   );

   function automatic logic [W-1:0] val(input int k);
      case (k)
         0: return 24'h000000;
         1: return 24'h800000;
         2: return 24'h3F0000;
         3: return 24'hBF0000;
         4: return 24'h400000;
         5: return 24'hC00000;
         6: return 24'h3F0001;
         default: return 24'h7FFFFF;
      endcase
   endfunction

   function automatic int key(input logic [W-1:0] v);
      int m;
      m = int'(v[W-2:0]);
      return v[W-1] ? -m : m;
   endfunction

   function automatic bit model_rel(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input int s);
      int ka, kb;
      ka = key(a);
      kb = key(b);
      case (s)
         0: return ka == kb;
         1: return ka != kb;
         2: return ka < kb;
         3: return ka <= kb;
         4: return ka > kb;
         default: return ka >= kb;
      endcase
   endfunction

   function automatic bit model_taken(input bit fx, input bit fy, input bit rx,
                                      input bit ry, input int md);
      bit mx, my;
      mx = (rx == fx);
      my = (ry == fy);
      case (md)
         0: return mx | my;
         1: return mx & my;
         2: return mx;
         default: return my;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_cmp(input logic [W-1:0] ax, input logic [W-1:0] bx, input int sx,
                         input logic [W-1:0] ay, input logic [W-1:0] by, input int sy,
                         input string req);
      @(negedge clk);
      a_x = ax; b_x = bx; sel_x = 3'(sx);
      a_y = ay; b_y = by; sel_y = 3'(sy);
      cmp_en = 1'b1;
      if (sx < 6) exp_fx = model_rel(ax, bx, sx);
      if (sy < 6) exp_fy = model_rel(ay, by, sy);
      @(posedge clk);
      #1;
      cmp_en = 1'b0;
      chk({req, " flag_x"}, int'(flag_x), int'(exp_fx));
      chk({req, " flag_y"}, int'(flag_y), int'(exp_fy));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset flag_x", int'(flag_x), 0);
      chk("R1 reset flag_y", int'(flag_y), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 after release flag_x", int'(flag_x), 0);
      chk("R1 after release flag_y", int'(flag_y), 0);

      // R3 R4 R5 R6 R7: sweep operand pairs and all selectors per lane
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            for (int s = 0; s < 8; s++) begin
               do_cmp(val(i), val(j), s, val(j), val(i), (s + 3) % 8,
                      "R3/R4/R5/R6/R7 sweep");
            end
         end
      end

      // R5: signed zeros are equal
      do_cmp(24'h000000, 24'h800000, 0, 24'h800000, 24'h000000, 2, "R5 zeros");
      chk("R5 eq x", int'(flag_x), 1);
      chk("R5 lt y", int'(flag_y), 0);

      // R2: compare disabled holds flags
      do_cmp(24'h400000, 24'h400000, 0, 24'h400000, 24'h400000, 0, "R2 set");
      @(negedge clk);
      a_x = 24'hC00000; b_x = 24'h400000; sel_x = 3'd0;
      a_y = 24'h000001; b_y = 24'h000002; sel_y = 3'd0;
      repeat (3) @(posedge clk);
      #1;
      chk("R2 idle flag_x", int'(flag_x), 1);
      chk("R2 idle flag_y", int'(flag_y), 1);

      // R8: every flag, reference and mode combination
      for (int f = 0; f < 4; f++) begin
         do_cmp(24'h3F0000, (f % 2) ? 24'h3F0000 : 24'hBF0000, 0,
                24'h3F0000, (f / 2) ? 24'h3F0000 : 24'hBF0000, 0, "R8 flag setup");
         for (int r = 0; r < 4; r++) begin
            for (int md = 0; md < 4; md++) begin
               @(negedge clk);
               ref_x = r[0]; ref_y = r[1]; mode = 2'(md);
               #1;
               chk("R8 taken", int'(taken),
                   int'(model_taken(f[0], f[1], r[0], r[1], md)));
            end
         end
      end

      // R9: compare and branch query in the same cycle
      do_cmp(24'h100000, 24'h100000, 0, 24'h100000, 24'h100000, 0, "R9 setup");
      @(negedge clk);
      ref_x = 1'b1; ref_y = 1'b1; mode = 2'd1;
      a_x = 24'h100000; b_x = 24'h100000; sel_x = 3'd1;
      a_y = 24'h100000; b_y = 24'h100000; sel_y = 3'd1;
      cmp_en = 1'b1;
      #1;
      chk("R9 taken before edge", int'(taken), 1);
      @(posedge clk);
      #1;
      cmp_en = 1'b0;
      chk("R9 taken after edge", int'(taken), 0);
      chk("R9 flag_x after edge", int'(flag_x), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule